// File: doc/BRIEF.md
# Double-Buffered OFDM Coded-Bit Interleaver

This block sits between a channel encoder and a constellation mapper in an OFDM transmitter. It collects the coded bits of one OFDM symbol, 16 bits per input transfer, and then hands them to the mapper one data subcarrier at a time. Each output transfer carries the bits of one subcarrier after a two-stage permutation. The first stage spreads neighbouring coded bits across distant subcarriers. The second stage alternates neighbouring bits between the low and high significance positions of the constellation point. Every symbol has 48 data subcarriers. A two-bit rate code, sampled on the first beat of each symbol, sets how many coded bits each subcarrier carries.

There are two symbol buffers, and they swap roles. While the mapper drains one buffer, the encoder can fill the other, so the fill time of a large symbol is hidden behind the readout of the previous one. Subcarriers leave in the order a 64-point inverse transform expects: the 24 positive-frequency data subcarriers first, in ascending frequency, and then the 24 negative-frequency ones, also ascending.

Both data interfaces use valid/ready. A beat moves on a rising clock edge when valid and ready are both high. The source must hold `in_bits` and `in_rate` steady while `in_valid` is high and `in_ready` is low. While `out_valid` is high and `out_ready` is low, the block holds `out_bits` and `out_rate` unchanged. Reset is synchronous and active high.

Top module: `ofdm_bit_interleaver`

## Requirements
- R1: During and right after reset, `in_ready` is 1 and `out_valid` is 0, and both buffers are empty.
- R2: Each accepted input beat carries 16 coded bits, with bit 0 the earliest. A symbol is complete after 48·Nbpsc/16 beats. Rate code 0, 1, 2 and 3 selects Nbpsc = 1, 2, 4 and 6, which gives symbols of 48, 96, 192 and 288 bits.
- R3: The rate code is taken only from the first beat of a symbol. Its value on the other beats of that symbol has no effect.
- R4: `out_valid` for a symbol rises in the cycle after that symbol's last input beat is accepted, and not earlier.
- R5: Number coded bits k = 0..N−1 in arrival order, with N = 48·Nbpsc and s = max(Nbpsc/2,1). Bit k goes to position j, where i = (N/16)(k mod 16) + ⌊k/16⌋ and j = s⌊i/s⌋ + (i + N − ⌊16i/N⌋) mod s. Data subcarrier d (0..47, ascending frequency) holds positions d·Nbpsc+b on `out_bits[b]`, for b < Nbpsc. The unused upper bits of `out_bits` are 0.
- R6: Output transfer t of a symbol (t = 0..47) carries data subcarrier t+24 when t < 24, and t−24 otherwise.
- R7: Exactly 48 output transfers are made per symbol, and symbols leave in the order they arrived.
- R8: `in_ready` goes low only when both buffers hold complete, unread symbols. A buffer is freed by the acceptance of its 48th subcarrier, and `in_ready` rises in the next cycle.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_bits` and `out_rate` stay unchanged in the next cycle.
- R10: `out_rate` shows the rate code latched for the symbol being read out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Block can accept an input beat |
| in_bits | input | 16 | Coded bits, bit 0 earliest |
| in_rate | input | 2 | Rate code, sampled on the first beat of a symbol |
| out_valid | output | 1 | A subcarrier's bits are offered |
| out_ready | input | 1 | Mapper accepts the subcarrier |
| out_bits | output | 6 | Bits of one subcarrier, bit b = constellation bit b |
| out_rate | output | 2 | Rate code of the symbol being read |

## Verification
On every cycle, the assertions check that the output holds still under back-pressure, that `in_ready` drops only when both buffers are full, that the latched rate stays put for the rest of a symbol, that `out_valid` rises only after an accepted input beat, and that the read counter stays in range. The bit permutation, the positive-first subcarrier order, the position of the final beat for each rate, and the fact that the rate code is ignored on later beats cannot be captured by those properties. The bench's reference model shows them. It computes the permutation in the forward direction, while the design computes the inverse, and it compares the results over full-rate, stalled and randomly throttled traffic.

// File: rtl/ilv_pkg.sv
`timescale 1ns/1ps
package ilv_pkg;
  localparam int COLS      = 16;
  localparam int IN_W      = 16;
  localparam int N_SC      = 48;
  localparam int MAX_BPSC  = 6;
  localparam int MAX_BITS  = N_SC * MAX_BPSC;
  localparam int GRP       = N_SC / COLS;
  localparam int HALF_SC   = N_SC / 2;
  localparam int MAX_BEATS = MAX_BITS / IN_W;
  localparam int ADDR_W    = $clog2(MAX_BITS);
  localparam int BEAT_W    = $clog2(MAX_BEATS + 1);
  localparam int SC_W      = $clog2(N_SC);

  typedef logic [1:0] rate_t;

  function automatic int bpsc(input rate_t r);
    case (r)
      2'd0:    return 1;
      2'd1:    return 2;
      2'd2:    return 4;
      default: return 6;
    endcase
  endfunction

  // Source bit index (arrival order) for bit b of stored subcarrier m.
  function automatic int src_bit(input int m, input int b, input rate_t r);
    int c;
    int i;
    int k;
    c = m / GRP;
    case (r)
      2'd0:    i = m;
      2'd1:    i = 2 * m + b;
      2'd2:    i = 4 * m + 2 * (b / 2) + ((b + c) % 2);
      default: i = 6 * m + 3 * (b / 3) + ((b + c) % 3);
    endcase
    k = COLS * i - (N_SC * bpsc(r) - 1) * c;
    if (k < 0 || k >= MAX_BITS) k = 0;
    return k;
  endfunction
endpackage

// File: rtl/ilv_wr_side.sv
`timescale 1ns/1ps
module ilv_wr_side
  import ilv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  rate_t             in_rate,
  input  logic [1:0]        full,
  output logic              in_ready,
  output logic              wr_we,
  output logic              wr_sel,
  output logic [ADDR_W-1:0] wr_base,
  output logic              wr_last,
  output rate_t             cur_rate
);
  logic [BEAT_W-1:0] wr_cnt;
  rate_t             wr_rate;
  int                beats;

  assign cur_rate = (wr_cnt == '0) ? in_rate : wr_rate;
  assign beats    = N_SC * bpsc(cur_rate) / IN_W;
  assign in_ready = !full[wr_sel];
  assign wr_we    = in_valid && in_ready;
  assign wr_last  = (int'(wr_cnt) == beats - 1);
  assign wr_base  = ADDR_W'(int'(wr_cnt) * IN_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_cnt  <= '0;
      wr_rate <= '0;
      wr_sel  <= 1'b0;
    end else if (wr_we) begin
      if (wr_cnt == '0) wr_rate <= in_rate;
      if (wr_last) begin
        wr_cnt <= '0;
        wr_sel <= !wr_sel;
      end else begin
        wr_cnt <= wr_cnt + 1'b1;
      end
    end
  end

  // R3: the latched rate holds for the rest of the symbol
  a_r3_rate_held: assert property (@(posedge clk) disable iff (rst)
    (wr_cnt != '0 && $past(wr_cnt) != '0) |-> $stable(wr_rate));
  // R8: ready drops only with both buffers occupied
  a_r8_ready_low_both_full: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> (full == 2'b11));
endmodule

// File: rtl/ilv_rd_side.sv
`timescale 1ns/1ps
module ilv_rd_side
  import ilv_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      full,
  input  logic            out_ready,
  output logic            out_valid,
  output logic            rd_sel,
  output logic            rd_clr,
  output logic [SC_W-1:0] sc_idx
);
  logic [SC_W-1:0] rd_cnt;
  logic            fire;

  assign out_valid = full[rd_sel];
  assign fire      = out_valid && out_ready;
  assign rd_clr    = fire && (int'(rd_cnt) == N_SC - 1);
  assign sc_idx    = (int'(rd_cnt) < HALF_SC) ? SC_W'(int'(rd_cnt) + HALF_SC)
                                              : SC_W'(int'(rd_cnt) - HALF_SC);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_cnt <= '0;
      rd_sel <= 1'b0;
    end else if (fire) begin
      if (rd_clr) begin
        rd_cnt <= '0;
        rd_sel <= !rd_sel;
      end else begin
        rd_cnt <= rd_cnt + 1'b1;
      end
    end
  end

  // R7: transfer counter never passes the subcarrier count
  a_r7_count_range: assert property (@(posedge clk) disable iff (rst)
    int'(rd_cnt) < N_SC);
endmodule

// File: rtl/ilv_bank_pair.sv
`timescale 1ns/1ps
module ilv_bank_pair
  import ilv_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_we,
  input  logic                wr_sel,
  input  logic [ADDR_W-1:0]   wr_base,
  input  logic                wr_last,
  input  logic [IN_W-1:0]     wr_bits,
  input  rate_t               wr_rate,
  input  logic                rd_sel,
  input  logic                rd_clr,
  input  logic [SC_W-1:0]     sc_idx,
  output logic [1:0]          full,
  output logic [MAX_BPSC-1:0] rd_bits,
  output rate_t               rd_rate
);
  logic [MAX_BITS-1:0] mem  [2];
  rate_t               rate_q [2];

  always_ff @(posedge clk) begin
    if (rst) begin
      full      <= 2'b00;
      rate_q[0] <= '0;
      rate_q[1] <= '0;
    end else begin
      if (wr_we && wr_last) begin
        full[wr_sel]   <= 1'b1;
        rate_q[wr_sel] <= wr_rate;
      end
      if (rd_clr) full[rd_sel] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_we) mem[wr_sel][wr_base +: IN_W] <= wr_bits;
  end

  assign rd_rate = rate_q[rd_sel];

  for (genvar b = 0; b < MAX_BPSC; b++) begin : g_lane
    logic [ADDR_W-1:0] src;
    assign src        = ADDR_W'(src_bit(int'(sc_idx), b, rd_rate));
    assign rd_bits[b] = (b < bpsc(rd_rate)) ? mem[rd_sel][src] : 1'b0;
  end
endmodule

// File: rtl/ofdm_bit_interleaver.sv
`timescale 1ns/1ps
module ofdm_bit_interleaver
  import ilv_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [IN_W-1:0]     in_bits,
  input  logic [1:0]          in_rate,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [MAX_BPSC-1:0] out_bits,
  output logic [1:0]          out_rate
);
  logic [1:0]        full;
  logic              wr_we, wr_sel, wr_last, rd_sel, rd_clr;
  logic [ADDR_W-1:0] wr_base;
  logic [SC_W-1:0]   sc_idx;
  rate_t             cur_rate;

  ilv_wr_side u_wr (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_rate(in_rate), .full(full),
    .in_ready(in_ready), .wr_we(wr_we), .wr_sel(wr_sel), .wr_base(wr_base),
    .wr_last(wr_last), .cur_rate(cur_rate)
  );

  ilv_rd_side u_rd (
    .clk(clk), .rst(rst), .full(full), .out_ready(out_ready),
    .out_valid(out_valid), .rd_sel(rd_sel), .rd_clr(rd_clr), .sc_idx(sc_idx)
  );

  ilv_bank_pair u_banks (
    .clk(clk), .rst(rst), .wr_we(wr_we), .wr_sel(wr_sel), .wr_base(wr_base),
    .wr_last(wr_last), .wr_bits(in_bits), .wr_rate(cur_rate), .rd_sel(rd_sel),
    .rd_clr(rd_clr), .sc_idx(sc_idx), .full(full), .rd_bits(out_bits),
    .rd_rate(out_rate)
  );

  // R9: offered subcarrier held under back-pressure
  a_r9_hold_under_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bits) && $stable(out_rate)));
  // R4: a symbol becomes readable only right after an accepted input beat
  a_r4_valid_after_write: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid && in_ready));
  // R1: empty after reset
  a_r1_reset_empty: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && in_ready));
endmodule

// File: tb/ofdm_bit_interleaver_test.sv
`timescale 1ns/1ps
module ofdm_bit_interleaver_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_bits = '0;
  logic [1:0]  in_rate = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [5:0]  out_bits;
  logic [1:0]  out_rate;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = !clk;

  ofdm_bit_interleaver uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_bits(in_bits), .in_rate(in_rate), .out_valid(out_valid),
    .out_ready(out_ready), .out_bits(out_bits), .out_rate(out_rate)
  );

  // reference model state
  logic [287:0] q_bits [$];
  int           q_rate [$];
  logic [287:0] part_bits = '0;
  int           part_cnt  = 0;
  int           part_rate = 0;
  int           rd_t      = 0;
  int           sym_in    = 0;
  int           sym_out   = 0;
  int           next_rate = 0;
  logic         prev_stall = 0;
  logic [5:0]   prev_bits  = '0;

  function automatic int nb_of(input int r);
    case (r) 0: return 1; 1: return 2; 2: return 4; default: return 6; endcase
  endfunction

  // forward permutation, then subcarrier pick (R5, R6)
  function automatic logic [5:0] expect_bits(input logic [287:0] src, input int r, input int t);
    logic [287:0] perm;
    logic [5:0]   res;
    int nb, n, s, d;
    nb = nb_of(r); n = 48 * nb; s = (nb / 2 > 1) ? nb / 2 : 1;
    perm = '0;
    for (int k = 0; k < n; k++) begin
      int i, j;
      i = (n / 16) * (k % 16) + k / 16;
      j = s * (i / s) + (i + n - (16 * i) / n) % s;
      perm[j] = src[k];
    end
    d = (t < 24) ? t + 24 : t - 24;
    res = '0;
    for (int b = 0; b < nb; b++) res[b] = perm[d * nb + b];
    return res;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock of stimulus plus comparison; rate_mode<0 means random per symbol
  task automatic step(input int p_in, input int p_out, input int rate_mode);
    bit in_fire, out_fire;
    @(negedge clk);
    in_valid  = ($urandom_range(99) < p_in);
    out_ready = ($urandom_range(99) < p_out);
    in_bits   = 16'($urandom);
    if (part_cnt == 0) begin
      next_rate = (rate_mode < 0) ? int'($urandom_range(3)) : rate_mode;
      in_rate   = 2'(next_rate);
    end else begin
      in_rate = 2'($urandom_range(3)); // R3: later-beat rate must be ignored
    end
    #1;
    check(in_ready == (q_rate.size() < 2), "R8 in_ready", in_ready, q_rate.size() < 2);
    check(out_valid == (q_rate.size() > 0), "R4 R2 out_valid", out_valid, q_rate.size() > 0);
    if (q_rate.size() > 0) begin
      logic [5:0] eb;
      eb = expect_bits(q_bits[0], q_rate[0], rd_t);
      check(out_bits == eb, "R5 R6 R3 out_bits", out_bits, eb);
      check(out_rate == 2'(q_rate[0]), "R10 out_rate", out_rate, q_rate[0]);
    end
    if (prev_stall) check(out_bits == prev_bits, "R9 hold", out_bits, prev_bits);
    prev_stall = out_valid && !out_ready;
    prev_bits  = out_bits;
    in_fire  = in_valid && (q_rate.size() < 2);
    out_fire = out_ready && (q_rate.size() > 0);
    if (out_fire) begin // R7: 48 transfers per symbol
      rd_t++;
      if (rd_t == 48) begin
        rd_t = 0;
        void'(q_bits.pop_front());
        void'(q_rate.pop_front());
        sym_out++;
      end
    end
    if (in_fire) begin // R2: 16 bits per beat, 3*Nbpsc beats per symbol
      if (part_cnt == 0) part_rate = int'(in_rate);
      part_bits[part_cnt * 16 +: 16] = in_bits;
      part_cnt++;
      if (part_cnt == 3 * nb_of(part_rate)) begin
        q_bits.push_back(part_bits);
        q_rate.push_back(part_rate);
        part_bits = '0;
        part_cnt  = 0;
        sym_in++;
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    @(negedge clk);
    rst = 1'b0;
    // each rate at full throughput
    for (int r = 0; r < 4; r++) repeat (160) step(100, 100, r);
    // stall the mapper: both buffers fill, ready must drop (R8)
    repeat (80) step(100, 0, 3);
    repeat (200) step(0, 100, 3);
    // mixed rates, heavy back-pressure on both sides (R9)
    repeat (6000) step(60, 40, -1);
    repeat (4000) step(90, 95, -1);
    // drain, then confirm symbol accounting (R7)
    repeat (400) step(0, 100, 0);
    check(sym_in == sym_out, "R7 symbol count", sym_out, sym_in);
    check(sym_in > 20, "R7 traffic", sym_in, 21);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule